// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor's word load/store port and a memory that moves whole lines. Each request carries a word address. The address is split into three parts: an offset within the line, a set index and a tag. The two ways of the indexed set are compared at the same time. A hit is served from the stored line without touching memory. On a miss, the block picks one way of the set to hold the incoming line. It writes that way's old contents back first when they were modified, then reads the new line and delivers the requested word.

Stores follow a write-back policy with write-allocate. A store that hits only updates the stored line and marks it modified. A store that misses first brings the whole line in, then merges the new word into it. Each set holds one recency bit that names its least recently used way. An empty way is always filled before any valid line is evicted, and way 0 is taken first when both ways are empty. Every hit and every fill makes the accessed way the most recently used one.

Top module: `cache2w`

## Requirements
- R1: After reset, every way of every set is invalid and modified bits and recency bits are cleared. `cpu_busy`, `cpu_done` and `mem_req` are low, so the first access to any address misses.
- R2: Address split for the defaults (8 sets, 16-byte lines). Word select is address bits [3:2], set index is bits [6:4] and tag is bits [31:7]. Every memory request carries a line-aligned byte address whose bits [3:0] are zero. A line read for a miss is issued at the requested address with bits [3:0] cleared.
- R3: A hit needs a valid way whose tag matches. The request is accepted on the clock edge where `cpu_req` is high and `cpu_busy` is low. The hit then raises `cpu_done` for exactly one cycle, on the second edge counted from that acceptance edge, and it raises no memory request.
- R4: On a miss, an invalid way of the set is filled in preference to evicting a valid line, and way 0 is taken when both ways are invalid. A second line mapping to a set that holds one line therefore does not evict the first.
- R5: On a miss with both ways valid, the least recently used way is replaced. Every hit and every fill makes the accessed way the most recently used.
- R6: A load returns on `cpu_rdata` the 32-bit word chosen by address bits [3:2]. Word k of a line occupies bits [32k+31:32k] of the line buses.
- R7: A store that hits updates only the addressed word of the stored line and marks the line modified. It raises no memory request, and `cpu_rdata` shows the stored word when `cpu_done` is high.
- R8: A store that misses reads the whole line from memory and merges the store word into it. Later loads of the other words in that line return the memory contents without a further miss.
- R9: When the chosen victim is valid and modified, its full line is written to the victim's own line address (`mem_we` high) before the line read for the miss is issued. A clean victim causes no write.
- R10: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until the edge where `mem_ack` is high. After a write-back is acknowledged, the next cycle carries the line read.
- R11: At most one way of a set can match a lookup tag. A double match is reported as an assertion failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_waddr | input | 30 | Word address (byte address bits [31:2]) |
| cpu_wdata | input | 32 | Store data |
| cpu_busy | output | 1 | High while an access is in progress |
| cpu_done | output | 1 | One-cycle pulse marking completion of an access |
| cpu_rdata | output | 32 | Load result, or the stored word for a store, valid with `cpu_done` |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wline | output | 128 | Line being written back |
| mem_rline | input | 128 | Line returned by memory, sampled with `mem_ack` |
| mem_ack | input | 1 | Completes the pending line transfer on this edge |

## Verification
The bound checker watches on every cycle that no lookup matches both ways and that completion is a single-cycle pulse. It also checks that a hit never raises a memory request, that line addresses are aligned and held steady until acknowledged, and that an acknowledged write-back is followed directly by the line read. Which way gets evicted, whether recency is updated on hits and fills, merging of store words and persistence of written-back data only show up over sequences of accesses. The bench's scenarios exercise these by filling, touching and evicting lines within one set and then checking which addresses still hit.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_WB   = 2'd2,
      ST_FILL = 2'd3
   } cst_e;
endpackage

// File: rtl/cache2w_tagcmp.sv
// Parallel tag comparison across all ways of one set.
module cache2w_tagcmp #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 25,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [WAYS-1:0]            way_vld,
   input  logic [TAG_W-1:0]           look_tag,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit_any,
   output logic [WAY_W-1:0]           hit_way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w] = way_vld[w] && (way_tag[w] == look_tag);
   end

   assign hit_any = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end
endmodule

// File: rtl/cache2w_victim.sv
// Replacement choice for a two-way set: empty way first, way 0 before way 1,
// otherwise the way named by the recency bit.
module cache2w_victim (
   input  logic [1:0] way_vld,
   input  logic       lru_way,
   output logic       victim
);
   always_comb begin
      if (!way_vld[0])      victim = 1'b0;
      else if (!way_vld[1]) victim = 1'b1;
      else                  victim = lru_way;
   end
endmodule

// File: rtl/cache2w_wsel.sv
// Word extraction from a line and word merge into a line.
module cache2w_wsel #(
   parameter int WPL    = 4,
   parameter int WORD_W = 32,
   localparam int SEL_W = $clog2(WPL)
) (
   input  logic [WPL*WORD_W-1:0] line_i,
   input  logic [SEL_W-1:0]      sel_i,
   input  logic                  wr_i,
   input  logic [WORD_W-1:0]     wdata_i,
   output logic [WORD_W-1:0]     word_o,
   output logic [WPL*WORD_W-1:0] line_o
);
   assign word_o = line_i[sel_i*WORD_W +: WORD_W];

   for (genvar k = 0; k < WPL; k++) begin : g_word
      assign line_o[k*WORD_W +: WORD_W] =
         (wr_i && (sel_i == SEL_W'(k))) ? wdata_i : line_i[k*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/cache2w.sv
module cache2w #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 8,
   parameter int WAYS       = 2,
   localparam int WORD_W = 32,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int IDX_W  = $clog2(SETS),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int WPL    = LINE_BYTES / 4,
   localparam int SEL_W  = $clog2(WPL),
   localparam int LINE_W = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:2] cpu_waddr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wline,
   input  logic [LINE_W-1:0] mem_rline,
   input  logic              mem_ack
);
   import cache2w_pkg::*;

   if (WAYS != 2) begin : g_bad_ways
      $error("cache2w supports exactly two ways");
   end
   if ((1 << OFF_W) != LINE_BYTES || LINE_BYTES < 8) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 8");
   end
   if ((1 << IDX_W) != SETS || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end

   // storage
   logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
   logic [WAYS-1:0][LINE_W-1:0] dat_q [SETS];
   logic [WAYS-1:0]             val_q [SETS];
   logic [WAYS-1:0]             dty_q [SETS];
   logic [SETS-1:0]             lru_q;

   // captured request
   cst_e              st_q;
   logic [ADDR_W-1:2] ra_q;
   logic              rwe_q;
   logic [WORD_W-1:0] rwd_q;
   logic              vic_q;
   logic              done_q;
   logic [WORD_W-1:0] rdata_q;

   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic [SEL_W-1:0] wsel;
   assign idx  = ra_q[OFF_W +: IDX_W];
   assign tag  = ra_q[ADDR_W-1 -: TAG_W];
   assign wsel = ra_q[2 +: SEL_W];

   logic [WAYS-1:0] hit_vec;
   logic            hit_any;
   logic            hit_way;
   logic            victim;

   cache2w_tagcmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
      .way_tag (tag_q[idx]),
      .way_vld (val_q[idx]),
      .look_tag(tag),
      .hit_vec (hit_vec),
      .hit_any (hit_any),
      .hit_way (hit_way)
   );

   cache2w_victim u_vic (
      .way_vld(val_q[idx]),
      .lru_way(lru_q[idx]),
      .victim (victim)
   );

   logic [WORD_W-1:0] hit_word, fill_word;
   logic [LINE_W-1:0] hit_line_new, fill_line_new;

   cache2w_wsel #(.WPL(WPL), .WORD_W(WORD_W)) u_hsel (
      .line_i(dat_q[idx][hit_way]), .sel_i(wsel), .wr_i(rwe_q), .wdata_i(rwd_q),
      .word_o(hit_word), .line_o(hit_line_new)
   );

   cache2w_wsel #(.WPL(WPL), .WORD_W(WORD_W)) u_fsel (
      .line_i(mem_rline), .sel_i(wsel), .wr_i(rwe_q), .wdata_i(rwd_q),
      .word_o(fill_word), .line_o(fill_line_new)
   );

   // array write controls
   logic              hit_now, fill_now;
   logic              arr_we;
   logic              arr_way;
   logic [LINE_W-1:0] arr_line;
   assign hit_now  = (st_q == ST_LOOK) && hit_any;
   assign fill_now = (st_q == ST_FILL) && mem_ack;
   assign arr_we   = (hit_now && rwe_q) || fill_now;
   assign arr_way  = fill_now ? vic_q : hit_way;
   assign arr_line = fill_now ? fill_line_new : hit_line_new;

   always_ff @(posedge clk) begin
      if (arr_we) dat_q[idx][arr_way] <= arr_line;
      if (fill_now) tag_q[idx][vic_q] <= tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ra_q    <= '0;
         rwe_q   <= 1'b0;
         rwd_q   <= '0;
         vic_q   <= 1'b0;
         done_q  <= 1'b0;
         rdata_q <= '0;
         lru_q   <= '0;
         for (int s = 0; s < SETS; s++) begin
            val_q[s] <= '0;
            dty_q[s] <= '0;
         end
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (cpu_req) begin
               ra_q  <= cpu_waddr;
               rwe_q <= cpu_we;
               rwd_q <= cpu_wdata;
               st_q  <= ST_LOOK;
            end
            ST_LOOK: if (hit_any) begin
               done_q     <= 1'b1;
               rdata_q    <= rwe_q ? rwd_q : hit_word;
               lru_q[idx] <= ~hit_way;
               if (rwe_q) dty_q[idx][hit_way] <= 1'b1;
               st_q       <= ST_IDLE;
            end else begin
               vic_q <= victim;
               st_q  <= (val_q[idx][victim] && dty_q[idx][victim]) ? ST_WB : ST_FILL;
            end
            ST_WB: if (mem_ack) st_q <= ST_FILL;
            ST_FILL: if (mem_ack) begin
               val_q[idx][vic_q] <= 1'b1;
               dty_q[idx][vic_q] <= rwe_q;
               lru_q[idx]        <= ~vic_q;
               done_q            <= 1'b1;
               rdata_q           <= rwe_q ? rwd_q : fill_word;
               st_q              <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_busy  = (st_q != ST_IDLE);
   assign cpu_done  = done_q;
   assign cpu_rdata = rdata_q;
   assign mem_req   = (st_q == ST_WB) || (st_q == ST_FILL);
   assign mem_we    = (st_q == ST_WB);
   assign mem_addr  = (st_q == ST_WB) ? {tag_q[idx][vic_q], idx, {OFF_W{1'b0}}}
                                      : {tag, idx, {OFF_W{1'b0}}};
   assign mem_wline = dat_q[idx][vic_q];
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4,
   parameter int WAYS   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_done,
   input logic               cpu_busy,
   input logic               mem_req,
   input logic               mem_we,
   input logic               mem_ack,
   input logic [ADDR_W-1:0]  mem_addr,
   input cache2w_pkg::cst_e  st_q,
   input logic [WAYS-1:0]    hit_vec
);
   import cache2w_pkg::*;

   p_one_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOOK) |-> $onehot0(hit_vec));

   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_busy);

   p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_LOOK) && (|hit_vec)) |=> (!mem_req && cpu_done));

   p_line_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0));

   p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_wb_then_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

bind cache2w cache2w_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cpu_done(cpu_done),
   .cpu_busy(cpu_busy),
   .mem_req (mem_req),
   .mem_we  (mem_we),
   .mem_ack (mem_ack),
   .mem_addr(mem_addr),
   .st_q    (st_q),
   .hit_vec (hit_vec)
);

// File: tb/cache2w_test.sv
`timescale 1ns/1ps
module cache2w_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0;
   logic         cpu_we = 1'b0;
   logic [31:2]  cpu_waddr = '0;
   logic [31:0]  cpu_wdata = '0;
   logic         cpu_busy, cpu_done;
   logic [31:0]  cpu_rdata;
   logic         mem_req, mem_we;
   logic [31:0]  mem_addr;
   logic [127:0] mem_wline;
   logic [127:0] mem_rline = '0;
   logic         mem_ack = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cache2w uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
      .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack)
   );

   int n_chk = 0;
   int n_fail = 0;
   int n_rd = 0;
   int n_wr = 0;
   logic [31:0] last_rd_addr = '0;
   logic [31:0] last_wb_addr = '0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: unwritten words hold a pattern derived from their address
   logic [31:0] mm [logic [31:0]];
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return mm.exists(a) ? mm[a] : (a ^ 32'h5A5A_0000);
   endfunction

   int          wcnt = 0;
   logic [31:0] held_addr = '0;
   logic        held_we = 1'b0;
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
         wcnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0;
         wcnt = 0;
      end else if (mem_req) begin
         if (wcnt == 0) begin
            held_addr = mem_addr;
            held_we = mem_we;
         end
         wcnt++;
         if (wcnt >= 3) begin
            // R10: request held steady while waiting
            check(mem_addr == held_addr && mem_we == held_we, "R10", mem_addr, held_addr);
            mem_ack = 1'b1;
            if (mem_we) begin
               n_wr++;
               last_wb_addr = mem_addr;
               for (int k = 0; k < 4; k++) mm[mem_addr + 32'(4*k)] = mem_wline[32*k +: 32];
            end else begin
               n_rd++;
               last_rd_addr = mem_addr;
               for (int k = 0; k < 4; k++) mem_rline[32*k +: 32] = mem_word(mem_addr + 32'(4*k));
            end
         end
      end
   end

   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat);
      @(negedge clk);
      while (cpu_busy) @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_waddr = a[31:2]; cpu_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0;
      lat = 1;
      while (!cpu_done) begin
         @(negedge clk);
         lat++;
      end
      rd = cpu_rdata;
   endtask

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [31:0] wd;
      logic [31:0] rd;
      logic [1:0]  nrd;
      logic [1:0]  nwr;
      logic [31:0] wba;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h014, 32'h0, 32'h5A5A0014, 2'd1, 2'd0, 32'h0,   4'd6}, // R1 R6 cold miss, way 0
      '{1'b0, 32'h018, 32'h0, 32'h5A5A0018, 2'd0, 2'd0, 32'h0,   4'd3}, // R3 hit, word 2
      '{1'b0, 32'h094, 32'h0, 32'h5A5A0094, 2'd1, 2'd0, 32'h0,   4'd4}, // R4 second line, empty way 1
      '{1'b0, 32'h010, 32'h0, 32'h5A5A0010, 2'd0, 2'd0, 32'h0,   4'd4}, // R4 first line kept
      '{1'b0, 32'h11C, 32'h0, 32'h5A5A011C, 2'd1, 2'd0, 32'h0,   4'd5}, // R5 evict LRU (0x090)
      '{1'b0, 32'h01C, 32'h0, 32'h5A5A001C, 2'd0, 2'd0, 32'h0,   4'd5}, // R5 MRU survived
      '{1'b1, 32'h114, 32'hDEAD0001, 32'hDEAD0001, 2'd0, 2'd0, 32'h0, 4'd7}, // R7 store hit
      '{1'b0, 32'h114, 32'h0, 32'hDEAD0001, 2'd0, 2'd0, 32'h0,   4'd7}, // R7 read back
      '{1'b0, 32'h090, 32'h0, 32'h5A5A0090, 2'd1, 2'd0, 32'h0,   4'd5}, // R5 store made way 1 MRU
      '{1'b0, 32'h198, 32'h0, 32'h5A5A0198, 2'd1, 2'd1, 32'h110, 4'd9}, // R9 dirty victim written
      '{1'b0, 32'h114, 32'h0, 32'hDEAD0001, 2'd1, 2'd0, 32'h0,   4'd9}, // R9 data persisted
      '{1'b1, 32'h228, 32'h12345678, 32'h12345678, 2'd1, 2'd0, 32'h0, 4'd8}, // R8 store miss
      '{1'b0, 32'h22C, 32'h0, 32'h5A5A022C, 2'd0, 2'd0, 32'h0,   4'd8}, // R8 rest of line
      '{1'b0, 32'h228, 32'h0, 32'h12345678, 2'd0, 2'd0, 32'h0,   4'd8}, // R8 merged word
      '{1'b0, 32'h2A0, 32'h0, 32'h5A5A02A0, 2'd1, 2'd0, 32'h0,   4'd4}, // R4 set 2 way 1
      '{1'b0, 32'h320, 32'h0, 32'h5A5A0320, 2'd1, 2'd1, 32'h220, 4'd9}, // R9 dirty allocated line
      '{1'b0, 32'h228, 32'h0, 32'h12345678, 2'd1, 2'd0, 32'h0,   4'd9}  // R9 persisted
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int lat;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(cpu_busy == 1'b0, "R1 busy", 32'(cpu_busy), 32'h0);
      check(cpu_done == 1'b0, "R1 done", 32'(cpu_done), 32'h0);
      check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         int rd0, wr0;
         string tg;
         rd0 = n_rd;
         wr0 = n_wr;
         tg = $sformatf("R%0d vec%0d", VEC[i].rq, i);
         access(VEC[i].we, VEC[i].addr, VEC[i].wd, rd, lat);
         check(rd == VEC[i].rd, {tg, " rdata"}, rd, VEC[i].rd);
         check(n_rd - rd0 == int'(VEC[i].nrd), {tg, " reads"}, 32'(n_rd - rd0), 32'(VEC[i].nrd));
         check(n_wr - wr0 == int'(VEC[i].nwr), {tg, " writes"}, 32'(n_wr - wr0), 32'(VEC[i].nwr));
         if (VEC[i].nrd == 2'd0)   // R3 hit latency
            check(lat == 2, {tg, " R3 latency"}, 32'(lat), 32'd2);
         else                      // R2 line address of the read
            check(last_rd_addr == (VEC[i].addr & ~32'hF), {tg, " R2 read addr"},
                  last_rd_addr, VEC[i].addr & ~32'hF);
         if (VEC[i].nwr != 2'd0)   // R9 victim line address
            check(last_wb_addr == VEC[i].wba, {tg, " R9 wb addr"}, last_wb_addr, VEC[i].wba);
      end

      // R3 completion lasts one cycle
      access(1'b0, 32'h228, 32'h0, rd, lat);
      @(negedge clk);
      check(cpu_done == 1'b0, "R3 pulse width", 32'(cpu_done), 32'h0);

      // R1 reset invalidates everything: a line just hit must miss again
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(cpu_busy == 1'b0 && mem_req == 1'b0, "R1 after reset", 32'({cpu_busy, mem_req}), 32'h0);
      rst_n = 1'b1;
      begin
         int rd0;
         rd0 = n_rd;
         access(1'b0, 32'h228, 32'h0, rd, lat);
         check(n_rd - rd0 == 1, "R1 miss after reset", 32'(n_rd - rd0), 32'd1);
         check(rd == 32'h12345678, "R6 word after reset", rd, 32'h12345678);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule